// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks reservations taken by one requester's load-linked operations, one flag per cache line. It watches every completed memory operation of that requester together with a hit indication from the cache lookup. From these it answers each store-conditional with a success bit. It also accepts invalidation notices from the coherence side: a line whose permission has been lost can no longer give a successful store-conditional. The flags sit in a small fully associative table. When the table is full, a reservation for a new line displaces the reservation that was allocated earliest.

Each operation presented with `op_valid` produces one registered response on the following cycle. The response carries the success bit and whether the operation's line is still reserved once the operation has been applied. An invalidation presented in the same cycle as an operation is applied before that operation. A bypass input turns the monitor off: every operation then reports success and leaves the table alone.

Top module: `llsc_monitor`

## Requirements
- R1: An operation with `op_valid`=1, `op_hit`=1, `bypass`=0 and `op_kind`=2'b00 (load-linked) reserves its line. Its response has `rsp_ok`=1 and `rsp_locked`=1.
- R2: A store-conditional (`op_kind`=2'b01, `op_hit`=1, `bypass`=0) responds with `rsp_ok`=1 when its line is reserved and with `rsp_ok`=0 when it is not.
- R3: Every store-conditional that reaches the table removes the reservation on its line, whether it succeeded or failed. Its response has `rsp_locked`=0, and a second store-conditional to the same line fails.
- R4: An ordinary write (`op_kind`=2'b10, `op_hit`=1, `bypass`=0) responds with `rsp_ok`=1 and `rsp_locked`=0 and removes the reservation on its own line only.
- R5: An operation with `op_hit`=0 responds with `rsp_ok`=1 and changes no reservation. `rsp_locked` reports the line's current reservation.
- R6: An invalidation (`inv_valid`=1) removes the reservation on `inv_line`. An invalidation of an unreserved line leaves the other reservations in place.
- R7: While `bypass`=1, every operation responds with `rsp_ok`=1 and changes no reservation.
- R8: When all ENTRIES slots are reserved, a load-linked to an unreserved line displaces the reservation allocated earliest. If a slot is free, the new reservation uses it and displaces nothing.
- R9: An invalidation and an operation in the same cycle act as if the invalidation came first. A store-conditional to the invalidated line therefore fails with `rsp_ok`=0.
- R10: A read (`op_kind`=2'b11) responds with `rsp_ok`=1, changes no reservation, and reports the line's reservation on `rsp_locked`.
- R11: After reset no line is reserved and `rsp_valid`=0. Each cycle with `op_valid`=1 yields `rsp_valid`=1 exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass | input | 1 | Disables the monitor; all operations report success |
| op_valid | input | 1 | A completed operation is presented |
| op_kind | input | 2 | 00 load-linked, 01 store-conditional, 10 write, 11 read |
| op_line | input | LINE_W | Line address of the operation |
| op_hit | input | 1 | Line is present in the cache lookup |
| inv_valid | input | 1 | Invalidation notice is presented |
| inv_line | input | LINE_W | Line address losing coherence permission |
| rsp_valid | output | 1 | Response for the operation of the previous cycle |
| rsp_ok | output | 1 | Store-conditional success bit (1 for every other operation) |
| rsp_locked | output | 1 | Line is reserved after the operation was applied |

## Verification
The bench builds the block with ENTRIES=4 and LINE_W=10. A four-slot table fills after four load-linked operations, so the bench can reach eviction of the earliest reservation, reuse of a hole left by a store-conditional, and displacement after such a hole within a short sequence. The narrow line address keeps the distinct test lines readable. The size is still enough to show that the associative match depends on the whole line address and not only on the slot.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LL = 2'b00,
        OP_SC = 2'b01,
        OP_WR = 2'b10,
        OP_RD = 2'b11
    } op_kind_e;

    typedef struct packed {
        logic valid;
        logic ok;
        logic locked;
    } rsp_t;

    function automatic logic kind_clears(op_kind_e k);
        return (k == OP_SC) || (k == OP_WR);
    endfunction

endpackage

// File: rtl/llsc_tag_cam.sv
module llsc_tag_cam #(
    parameter int ENTRIES = 4,
    parameter int LINE_W  = 10
) (
    input  logic [ENTRIES-1:0][LINE_W-1:0] tags,
    input  logic [ENTRIES-1:0]             valid,
    input  logic [LINE_W-1:0]              line,
    output logic [ENTRIES-1:0]             match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == line);
    end
endmodule

// File: rtl/llsc_age_order.sv
module llsc_age_order #(
    parameter int ENTRIES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] alloc,
    input  logic [ENTRIES-1:0] valid,
    output logic [ENTRIES-1:0] oldest
);
    // older_q[i][j] = 1 : slot i was allocated before slot j
    logic [ENTRIES-1:0][ENTRIES-1:0] older_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            older_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                for (int j = 0; j < ENTRIES; j++) begin
                    if (alloc[i])
                        older_q[i][j] <= 1'b0;
                    else if (alloc[j] && (i != j))
                        older_q[i][j] <= 1'b1;
                end
            end
        end
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_old
        localparam logic [ENTRIES-1:0] SELF = {{(ENTRIES-1){1'b0}}, 1'b1} << i;
        assign oldest[i] = valid[i] && (&(older_q[i] | ~valid | SELF));
    end
endmodule

// File: rtl/llsc_slot_alloc.sv
module llsc_slot_alloc #(
    parameter int ENTRIES = 4
) (
    input  logic               want,
    input  logic [ENTRIES-1:0] valid,
    input  logic [ENTRIES-1:0] oldest,
    output logic [ENTRIES-1:0] alloc
);
    logic [ENTRIES-1:0] free_vec;
    logic [ENTRIES-1:0] first_free;

    assign free_vec   = ~valid;
    assign first_free = free_vec & (~free_vec + ENTRIES'(1));

    always_comb begin
        alloc = '0;
        if (want)
            alloc = (|free_vec) ? first_free : oldest;
    end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int LINE_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bypass,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [LINE_W-1:0] op_line,
    input  logic              op_hit,
    input  logic              inv_valid,
    input  logic [LINE_W-1:0] inv_line,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic              rsp_locked
);
    logic [ENTRIES-1:0][LINE_W-1:0] tag_q;
    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0]             inv_match, inv_clr, valid_mid;
    logic [ENTRIES-1:0]             op_match, clr_vec, alloc_vec, oldest, valid_d;
    logic                           matched, active, want_alloc;
    op_kind_e                       kind;
    rsp_t                           rsp_d, rsp_q;

    // invalidation is applied before the operation
    llsc_tag_cam #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) inv_cam_i (
        .tags(tag_q), .valid(valid_q), .line(inv_line), .match(inv_match)
    );
    assign inv_clr   = inv_valid ? inv_match : '0;
    assign valid_mid = valid_q & ~inv_clr;

    llsc_tag_cam #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) op_cam_i (
        .tags(tag_q), .valid(valid_mid), .line(op_line), .match(op_match)
    );

    assign kind       = op_kind_e'(op_kind);
    assign matched    = |op_match;
    assign active     = op_valid && !bypass && op_hit;
    assign want_alloc = active && (kind == OP_LL) && !matched;
    assign clr_vec    = (active && kind_clears(kind)) ? op_match : '0;

    llsc_age_order #(.ENTRIES(ENTRIES)) age_i (
        .clk(clk), .rst(rst), .alloc(alloc_vec), .valid(valid_mid), .oldest(oldest)
    );

    llsc_slot_alloc #(.ENTRIES(ENTRIES)) alloc_i (
        .want(want_alloc), .valid(valid_mid), .oldest(oldest), .alloc(alloc_vec)
    );

    assign valid_d = (valid_mid & ~clr_vec) | alloc_vec;

    always_comb begin
        rsp_d.valid  = op_valid;
        rsp_d.ok     = !(active && (kind == OP_SC) && !matched);
        rsp_d.locked = matched;
        if (active) begin
            if (kind == OP_LL)
                rsp_d.locked = 1'b1;
            else if (kind_clears(kind))
                rsp_d.locked = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            tag_q   <= '0;
            rsp_q   <= '0;
        end else begin
            valid_q <= valid_d;
            rsp_q   <= rsp_d;
            for (int i = 0; i < ENTRIES; i++)
                if (alloc_vec[i])
                    tag_q[i] <= op_line;
        end
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_ok     = rsp_q.ok;
    assign rsp_locked = rsp_q.locked;
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int ENTRIES = 4,
    parameter int LINE_W  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              bypass,
    input logic              op_valid,
    input logic [1:0]        op_kind,
    input logic [LINE_W-1:0] op_line,
    input logic              op_hit,
    input logic              inv_valid,
    input logic [LINE_W-1:0] inv_line,
    input logic              rsp_valid,
    input logic              rsp_ok,
    input logic              rsp_locked,
    input logic [ENTRIES-1:0] valid_mid,
    input logic [ENTRIES-1:0] oldest
);
    logic act;
    assign act = op_valid && !bypass && op_hit;

    AST_RSP_TIMING: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rsp_valid == $past(op_valid)));                       // R11
    AST_BYPASS_OK: assert property (@(posedge clk) disable iff (rst)
        (op_valid && bypass) |=> rsp_ok);                               // R7
    AST_MISS_OK: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_hit) |=> rsp_ok);                              // R5
    AST_LL_LOCKS: assert property (@(posedge clk) disable iff (rst)
        (act && op_kind == 2'b00) |=> (rsp_ok && rsp_locked));          // R1
    AST_SC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (act && op_kind == 2'b01) |=> !rsp_locked);                     // R3
    AST_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (act && op_kind == 2'b10) |=> (rsp_ok && !rsp_locked));         // R4
    AST_INV_WINS: assert property (@(posedge clk) disable iff (rst)
        (act && op_kind == 2'b01 && inv_valid && inv_line == op_line)
        |=> !rsp_ok);                                                   // R9
    AST_ONE_VICTIM: assert property (@(posedge clk) disable iff (rst)
        (&valid_mid) |-> $onehot(oldest));                              // R8
endmodule

bind llsc_monitor llsc_monitor_chk #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) chk_i (
    .clk(clk), .rst(rst), .bypass(bypass), .op_valid(op_valid), .op_kind(op_kind),
    .op_line(op_line), .op_hit(op_hit), .inv_valid(inv_valid), .inv_line(inv_line),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_locked(rsp_locked),
    .valid_mid(valid_mid), .oldest(oldest)
);

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 4;
    localparam int LINE_W     = 10;

    localparam logic [1:0] K_LL = 2'b00, K_SC = 2'b01, K_WR = 2'b10, K_RD = 2'b11;

    logic clk = 1'b0, rst = 1'b1;
    logic bypass = 0, op_valid = 0, op_hit = 0, inv_valid = 0;
    logic [1:0] op_kind = '0;
    logic [LINE_W-1:0] op_line = '0, inv_line = '0;
    logic rsp_valid, rsp_ok, rsp_locked;

    int vectors = 0, miscompares = 0;
    int mdl[$];                 // reserved lines, earliest first
    bit exp_ok_q[$], exp_lk_q[$];
    string exp_req_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    llsc_monitor #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) dut_i (
        .clk(clk), .rst(rst), .bypass(bypass), .op_valid(op_valid), .op_kind(op_kind),
        .op_line(op_line), .op_hit(op_hit), .inv_valid(inv_valid), .inv_line(inv_line),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_locked(rsp_locked)
    );

    function automatic int find_line(int ln);
        for (int i = 0; i < mdl.size(); i++)
            if (mdl[i] == ln) return i;
        return -1;
    endfunction

    task automatic send(input logic [1:0] k, input int ln, input bit hit, input bit byp,
                        input bit iv, input int il, input string rq);
        int idx;
        bit eok, elk;
        @(negedge clk);
        op_valid = 1; op_kind = k; op_line = LINE_W'(ln); op_hit = hit;
        bypass = byp; inv_valid = iv; inv_line = LINE_W'(il);
        if (iv) begin
            idx = find_line(il);
            if (idx >= 0) mdl.delete(idx);
        end
        idx = find_line(ln);
        eok = 1; elk = (idx >= 0);
        if (hit && !byp) begin
            case (k)
                K_LL: begin
                    if (idx < 0) begin
                        if (mdl.size() == ENTRIES) void'(mdl.pop_front());
                        mdl.push_back(ln);
                    end
                    elk = 1;
                end
                K_SC: begin
                    eok = (idx >= 0);
                    if (idx >= 0) mdl.delete(idx);
                    elk = 0;
                end
                K_WR: begin
                    if (idx >= 0) mdl.delete(idx);
                    elk = 0;
                end
                default: ;
            endcase
        end
        exp_ok_q.push_back(eok); exp_lk_q.push_back(elk); exp_req_q.push_back(rq);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid = 0; inv_valid = 0; bypass = 0;
        end
    endtask

    // monitor: pops expected items as responses appear
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rsp_valid) begin
                vectors++;
                if (exp_ok_q.size() == 0) begin
                    miscompares++;
                    $display("FAIL R11 unexpected response: rsp_valid=1 expected 0");
                end else begin
                    automatic bit eok = exp_ok_q.pop_front();
                    automatic bit elk = exp_lk_q.pop_front();
                    automatic string rq = exp_req_q.pop_front();
                    if (rsp_ok !== eok || rsp_locked !== elk) begin
                        miscompares++;
                        $display("FAIL %s ok/locked actual %b/%b expected %b/%b",
                                 rq, rsp_ok, rsp_locked, eok, elk);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        miscompares++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        vectors++;                                          // R11 reset state
        if (rsp_valid !== 1'b0) begin
            miscompares++;
            $display("FAIL R11 rsp_valid after reset actual %b expected 0", rsp_valid);
        end
        send(K_RD, 'h10, 1, 0, 0, 0, "R11");                // nothing reserved at reset
        send(K_SC, 'h10, 1, 0, 0, 0, "R2");                 // unreserved SC fails
        send(K_LL, 'h10, 1, 0, 0, 0, "R1");
        send(K_RD, 'h10, 1, 0, 0, 0, "R10");
        send(K_SC, 'h10, 1, 0, 0, 0, "R2");                 // succeeds
        send(K_SC, 'h10, 1, 0, 0, 0, "R3");                 // cleared by SC
        send(K_LL, 'h11, 1, 0, 0, 0, "R1");
        send(K_SC, 'h12, 1, 0, 0, 0, "R3");                 // failed SC other line
        send(K_SC, 'h11, 1, 0, 0, 0, "R3");                 // 0x11 untouched
        send(K_LL, 'h20, 1, 0, 0, 0, "R1");
        send(K_WR, 'h20, 1, 0, 0, 0, "R4");
        send(K_SC, 'h20, 1, 0, 0, 0, "R4");
        send(K_LL, 'h30, 1, 0, 0, 0, "R1");
        send(K_WR, 'h31, 1, 0, 0, 0, "R4");
        send(K_SC, 'h30, 1, 0, 0, 0, "R4");
        send(K_LL, 'h40, 1, 0, 0, 0, "R1");
        send(K_SC, 'h40, 0, 0, 0, 0, "R5");                 // miss: ok, stays reserved
        send(K_WR, 'h40, 0, 0, 0, 0, "R5");
        send(K_SC, 'h40, 1, 0, 0, 0, "R5");
        send(K_LL, 'h41, 0, 0, 0, 0, "R5");                 // miss LL reserves nothing
        send(K_RD, 'h41, 1, 0, 0, 0, "R5");
        send(K_LL, 'h50, 1, 0, 0, 0, "R1");
        send(K_RD, 'h50, 1, 0, 1, 'h51, "R6");              // other line invalidated
        send(K_RD, 'h50, 1, 0, 1, 'h50, "R6");
        send(K_SC, 'h50, 1, 0, 0, 0, "R6");
        send(K_LL, 'h60, 1, 1, 0, 0, "R7");
        send(K_SC, 'h60, 1, 1, 0, 0, "R7");
        send(K_SC, 'h60, 1, 0, 0, 0, "R7");
        send(K_LL, 'h61, 1, 0, 0, 0, "R1");
        send(K_SC, 'h61, 1, 1, 0, 0, "R7");
        send(K_WR, 'h61, 1, 1, 0, 0, "R7");
        send(K_SC, 'h61, 1, 0, 0, 0, "R7");
        for (int i = 0; i < 5; i++)
            send(K_LL, 'h70 + i, 1, 0, 0, 0, "R8");
        for (int i = 0; i < 5; i++)
            send(K_RD, 'h70 + i, 1, 0, 0, 0, "R8");         // 0x70 evicted
        send(K_SC, 'h71, 1, 0, 0, 0, "R8");                 // leaves a hole
        send(K_LL, 'h75, 1, 0, 0, 0, "R8");                 // fills hole
        send(K_RD, 'h72, 1, 0, 0, 0, "R8");
        send(K_LL, 'h76, 1, 0, 0, 0, "R8");                 // evicts 0x72
        send(K_RD, 'h72, 1, 0, 0, 0, "R8");
        send(K_RD, 'h73, 1, 0, 0, 0, "R8");
        send(K_RD, 'h75, 1, 0, 0, 0, "R8");
        send(K_LL, 'h80, 1, 0, 0, 0, "R1");
        send(K_SC, 'h80, 1, 0, 1, 'h80, "R9");              // invalidation first
        send(K_LL, 'h81, 1, 0, 1, 'h81, "R9");              // LL after inv holds
        send(K_SC, 'h81, 1, 0, 0, 0, "R9");
        idle(1);
        @(negedge clk); inv_valid = 1; inv_line = 'h73;     // bare invalidation
        idle(1);
        send(K_RD, 'h73, 1, 0, 0, 0, "R6");
        send(K_RD, 'h74, 1, 0, 0, 0, "R6");
        idle(4);
        vectors++;
        if (exp_ok_q.size() != 0) begin
            miscompares++;
            $display("FAIL R11 missing responses actual %0d pending expected 0", exp_ok_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule